// File: doc/BRIEF.md
# Zero-Crossing Stereo Gain and Mute Controller

This block scales two independent streams of signed PCM samples, left and right, by a gain picked from a volume code. A simple write port sets a volume code for each channel and a control word with two bits. One bit requests a general mute. The other selects whether mute changes wait for a zero crossing. Volume changes are never applied at once. Each new code is held pending and takes effect at the next zero crossing of that channel's own signal. Steps in gain therefore land where the waveform is near zero and do not click.

Overlapping writes follow fixed rules. If a new code arrives while an older one is still pending, the older one is applied in that cycle and the new one is armed in its place. A later write therefore always pushes a stalled value through. Going from the lowest gain step to the mute code needs no crossing. Every other move into mute waits for one, like any other step. Samples arrive with a shared strobe. Each result is registered and appears one cycle later.

Top module: `zc_gain_ctrl`

## Requirements
- R1: Volume code k in 0..87 selects a gain of (16 - k) dB. Codes 88..127 (wr_data_i[6:0]) are the mute code and give output 0. The gain is built as follows. With t = 88 - k, let r = t mod 6 and s = 26 - floor(t/6). The output is (x*M[r] + 2^(s-1)) >>> s, where M = {16384, 18383, 20626, 23143, 25967, 29135}.
- R2: The outputs are registered. valid_o equals valid_i of the previous cycle. left_o and right_o update only on a valid sample and otherwise hold their value. Results are rounded as in R1 and then saturated to the signed sample range.
- R3: A valid sample is a zero crossing when it equals zero, or when its sign bit differs from the sign bit of the previous valid sample of the same channel. The stored sign resets to non-negative.
- R4: A volume write (wr_addr_i 0 = left, 1 = right) is armed and not applied until a zero crossing on a later valid sample of that channel. The sample at that crossing already uses the new gain.
- R5: Each channel's pending value is applied only by that channel's own zero crossing.
- R6: A volume write to a channel whose earlier value is still pending applies the earlier value in the write cycle and arms the new one.
- R7: If the value in effect after R6 is code 87 and the written code is mute, mute is applied at once. A mute write from any other step is armed as in R4.
- R8: Control writes go to wr_addr_i 2: bit 0 is general mute, bit 1 selects zero-crossing mute timing. When bit 1 is 0, general mute silences both outputs from the next sample onward, and clearing it restores them at once.
- R9: When zero-crossing mute timing is on, a change of general mute takes effect on each channel at that channel's next zero crossing on a later sample.
- R10: Writing the control word with bit 1 cleared applies the written general mute state to both channels at once, which releases any mute change still pending.
- R11: After reset both channels hold the mute code with nothing pending, general mute and zero-crossing mute timing are cleared, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | 0 left volume, 1 right volume, 2 control, 3 unused |
| wr_data_i | input | 8 | Volume code in [6:0], or control bits [1:0] |
| valid_i | input | 1 | Sample strobe for both channels |
| left_i | input | 16 | Left sample, signed |
| right_i | input | 16 | Right sample, signed |
| valid_o | output | 1 | Output strobe, one cycle after valid_i |
| left_o | output | 16 | Scaled left sample |
| right_o | output | 16 | Scaled right sample |

## Verification
The assertions check the following on every cycle. The output strobe follows the input strobe. An applied gain never moves without a write or a crossing, and a crossing drains anything pending. A mute write from a step other than the lowest stays pending. Direct general mute zeroes both outputs. Clearing zero-crossing mute timing sets the applied mute state. Only the bench scenarios can show the numeric gains, rounding and saturation. They also cover the back-to-back write ordering, the lowest-step shortcut into mute, the way a zero-valued sample counts as a crossing, and the fact that mute timing follows each channel's own crossings.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
  localparam int unsigned MAX_DB     = 16;
  localparam int unsigned NUM_STEPS  = 88;
  localparam int unsigned MUTE_CODE  = NUM_STEPS;
  localparam int unsigned MIN_CODE   = NUM_STEPS - 1;
  localparam int unsigned CODE_W     = $clog2(NUM_STEPS + 1);
  localparam int unsigned FRAC_W     = 14;
  // lowest dB rounded down to a multiple of 6 so t = code distance stays >= 0
  localparam int unsigned DB_BIAS    = 6 * ((NUM_STEPS - 1 - MAX_DB + 5) / 6);
  localparam int unsigned TOP_T      = MAX_DB + DB_BIAS;
  localparam int unsigned SHIFT_BASE = FRAC_W + DB_BIAS / 6;
  localparam int unsigned SH_W       = $clog2(SHIFT_BASE + 1);

  typedef enum logic [1:0] {
    ADDR_VOL_L = 2'd0,
    ADDR_VOL_R = 2'd1,
    ADDR_CTRL  = 2'd2,
    ADDR_NONE  = 2'd3
  } wr_addr_e;

  // 10^(r/20) in Q14 for the 1 dB fraction of a 6 dB octave
  function automatic logic [15:0] mant(input logic [2:0] r);
    case (r)
      3'd0:    mant = 16'd16384;
      3'd1:    mant = 16'd18383;
      3'd2:    mant = 16'd20626;
      3'd3:    mant = 16'd23143;
      3'd4:    mant = 16'd25967;
      default: mant = 16'd29135;
    endcase
  endfunction
endpackage

// File: rtl/zcg_zc_detect.sv
module zcg_zc_detect #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                zc_o
);
  logic neg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      neg_q <= 1'b0;
    else if (valid_i) neg_q <= sample_i[SAMPLE_W-1];
  end

  assign zc_o = valid_i && ((sample_i == '0) || (sample_i[SAMPLE_W-1] != neg_q));
endmodule

// File: rtl/zcg_scaler.sv
module zcg_scaler
  import zcg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [CODE_W-1:0]   code_i,
  input  logic                mute_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int unsigned PROD_W = SAMPLE_W + 17;
  localparam int unsigned ACC_W  = PROD_W + 1;
  localparam logic signed [ACC_W-1:0] S_MAX = ACC_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] S_MIN = -S_MAX - ACC_W'(1);

  logic [CODE_W-1:0]        t, t_hi;
  logic [2:0]               t_lo;
  logic [SH_W-1:0]          sh;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc, shifted;
  logic [SAMPLE_W-1:0]      result;

  always_comb begin
    t       = CODE_W'(TOP_T) - code_i;
    t_hi    = t / CODE_W'(6);
    t_lo    = 3'(t % CODE_W'(6));
    sh      = SH_W'(SHIFT_BASE) - SH_W'(t_hi);
    prod    = $signed(sample_i) * $signed({1'b0, mant(t_lo)});
    acc     = {prod[PROD_W-1], prod} + (ACC_W'(1) << (sh - SH_W'(1)));
    shifted = acc >>> sh;
    if (mute_i || (code_i >= CODE_W'(MUTE_CODE))) result = '0;
    else if (shifted > S_MAX)                     result = S_MAX[SAMPLE_W-1:0];
    else if (shifted < S_MIN)                     result = S_MIN[SAMPLE_W-1:0];
    else                                          result = shifted[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sample_o <= '0;
    else if (valid_i) sample_o <= result;
  end
endmodule

// File: rtl/zcg_chan.sv
module zcg_chan
  import zcg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                vol_we_i,
  input  logic [CODE_W-1:0]   vol_code_i,
  input  logic                gm_req_i,
  input  logic                gm_req_nxt_i,
  input  logic                zcm_nxt_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [CODE_W-1:0]   applied_o,
  output logic                pend_vld_o,
  output logic                mute_o,
  output logic                zc_o
);
  logic [CODE_W-1:0] applied_q, applied_d, pend_q, pend_d, base;
  logic              pend_vld_q, pend_vld_d, mute_q, mute_d, zc;

  zcg_zc_detect #(.SAMPLE_W(SAMPLE_W)) i_zc (
    .clk_i, .rst_ni, .valid_i, .sample_i, .zc_o(zc)
  );

  always_comb begin
    base       = pend_vld_q ? pend_q : applied_q;
    applied_d  = applied_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    if (vol_we_i) begin
      // older value first; lowest step to mute skips the crossing
      if ((base == CODE_W'(MIN_CODE)) && (vol_code_i >= CODE_W'(MUTE_CODE))) begin
        applied_d  = vol_code_i;
        pend_vld_d = 1'b0;
      end else begin
        applied_d  = base;
        pend_d     = vol_code_i;
        pend_vld_d = 1'b1;
      end
    end else if (zc && pend_vld_q) begin
      applied_d  = pend_q;
      pend_vld_d = 1'b0;
    end

    if (!zcm_nxt_i) mute_d = gm_req_nxt_i;
    else if (zc)    mute_d = gm_req_i;
    else            mute_d = mute_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      applied_q  <= CODE_W'(MUTE_CODE);
      pend_q     <= CODE_W'(MUTE_CODE);
      pend_vld_q <= 1'b0;
      mute_q     <= 1'b0;
    end else begin
      applied_q  <= applied_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
      mute_q     <= mute_d;
    end
  end

  zcg_scaler #(.SAMPLE_W(SAMPLE_W)) i_scaler (
    .clk_i, .rst_ni, .valid_i, .sample_i,
    .code_i(applied_d), .mute_i(mute_d), .sample_o
  );

  assign applied_o  = applied_q;
  assign pend_vld_o = pend_vld_q;
  assign mute_o     = mute_q;
  assign zc_o       = zc;
endmodule

// File: rtl/zc_gain_ctrl.sv
module zc_gain_ctrl
  import zcg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DATA_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [1:0]          wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  localparam int unsigned NCH = 2;

  logic                          gm_q, zcm_q, gm_nxt, zcm_nxt, ctrl_we;
  logic [NCH-1:0][SAMPLE_W-1:0]  smp_in, smp_out;
  logic [NCH-1:0][CODE_W-1:0]    applied;
  logic [NCH-1:0]                pend_vld, mute_app, zc;

  assign ctrl_we = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign gm_nxt  = ctrl_we ? wr_data_i[0] : gm_q;
  assign zcm_nxt = ctrl_we ? wr_data_i[1] : zcm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gm_q    <= 1'b0;
      zcm_q   <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      gm_q    <= gm_nxt;
      zcm_q   <= zcm_nxt;
      valid_o <= valid_i;
    end
  end

  assign smp_in[0] = left_i;
  assign smp_in[1] = right_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zcg_chan #(.SAMPLE_W(SAMPLE_W)) i_chan (
      .clk_i, .rst_ni, .valid_i,
      .sample_i    (smp_in[c]),
      .vol_we_i    (wr_en_i && (wr_addr_i == 2'(c))),
      .vol_code_i  (wr_data_i[CODE_W-1:0]),
      .gm_req_i    (gm_q),
      .gm_req_nxt_i(gm_nxt),
      .zcm_nxt_i   (zcm_nxt),
      .sample_o    (smp_out[c]),
      .applied_o   (applied[c]),
      .pend_vld_o  (pend_vld[c]),
      .mute_o      (mute_app[c]),
      .zc_o        (zc[c])
    );
  end

  assign left_o  = smp_out[0];
  assign right_o = smp_out[1];
endmodule

// File: rtl/zcg_checker.sv
module zcg_checker
  import zcg_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DATA_W   = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [1:0]                 wr_addr_i,
  input logic [DATA_W-1:0]          wr_data_i,
  input logic                       valid_i,
  input logic                       valid_o,
  input logic [SAMPLE_W-1:0]        left_o,
  input logic [SAMPLE_W-1:0]        right_o,
  input logic [1:0][CODE_W-1:0]     applied,
  input logic [1:0]                 pend_vld,
  input logic [1:0]                 mute_app,
  input logic [1:0]                 zc,
  input logic                       gm_q,
  input logic                       zcm_q
);
  logic ctrl_we;
  assign ctrl_we = wr_en_i && (wr_addr_i == ADDR_CTRL);

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R2
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R2
  AST_GMUTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && gm_q && !zcm_q && !wr_en_i |=> (left_o == '0) && (right_o == '0));  // R8

  for (genvar c = 0; c < 2; c++) begin : g_chk
    logic vol_we;
    assign vol_we = wr_en_i && (wr_addr_i == 2'(c));

    AST_HOLD_NO_XING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !vol_we && !zc[c] |=> $stable(applied[c]));  // R4
    AST_PEND_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_vld[c] && zc[c] && !vol_we |=> !pend_vld[c]);  // R4
    AST_STEP_TO_MUTE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vol_we && !pend_vld[c] && (applied[c] < CODE_W'(MIN_CODE))
      && (wr_data_i[CODE_W-1:0] >= CODE_W'(MUTE_CODE)) |=> pend_vld[c]);  // R7
    AST_ZCM_CLEAR_APPLIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl_we && !wr_data_i[1] |=> mute_app[c] == $past(wr_data_i[0]));  // R10
  end
endmodule

bind zc_gain_ctrl zcg_checker #(.SAMPLE_W(SAMPLE_W), .DATA_W(DATA_W)) i_zcg_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .valid_i(valid_i), .valid_o(valid_o),
  .left_o(left_o), .right_o(right_o), .applied(applied), .pend_vld(pend_vld),
  .mute_app(mute_app), .zc(zc), .gm_q(gm_q), .zcm_q(zcm_q)
);

// File: tb/test_zc_gain_ctrl.sv
`timescale 1ns/1ps
module test_zc_gain_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        valid_i = 1'b0;
  logic [15:0] left_i = '0, right_i = '0;
  logic        valid_o;
  logic [15:0] left_o, right_o;

  int tests = 0, fails = 0;
  bit done = 0, started = 0;
  string cur_req = "R11";

  always #2.5 clk_i = ~clk_i;

  zc_gain_ctrl i_zc_gain_ctrl (.*);

  // ---------------- behavioural reference ----------------
  int ap[2], pd[2];
  bit pv[2], mu[2], pn[2];
  bit gm, zcm;
  int exp_l, exp_r;
  bit exp_v;

  function automatic int model_scale(int x, int code);
    int m[6] = '{16384, 18383, 20626, 23143, 25967, 29135};
    int t, s;
    longint p, v;
    t = 88 - code;
    s = 26 - t / 6;
    p = longint'(x) * m[t % 6];
    v = (p + (longint'(1) << (s - 1))) >>> s;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return int'(v);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin ap[c] = 88; pd[c] = 88; pv[c] = 0; mu[c] = 0; pn[c] = 0; end
      gm = 0; zcm = 0; exp_l = 0; exp_r = 0; exp_v = 0;
    end else begin
      bit gmn, zcmn;
      gmn = gm; zcmn = zcm;
      if (wr_en_i && wr_addr_i == 2) begin gmn = wr_data_i[0]; zcmn = wr_data_i[1]; end
      for (int c = 0; c < 2; c++) begin
        int x, code, base, y;
        bit xing;
        x = (c == 0) ? int'($signed(left_i)) : int'($signed(right_i));
        xing = valid_i && (x == 0 || ((x < 0) != pn[c]));
        code = int'(wr_data_i[6:0]);
        if (wr_en_i && wr_addr_i == c) begin
          base = pv[c] ? pd[c] : ap[c];
          if (base == 87 && code >= 88) begin ap[c] = code; pv[c] = 0; end
          else begin ap[c] = base; pd[c] = code; pv[c] = 1; end
        end else if (xing && pv[c]) begin
          ap[c] = pd[c]; pv[c] = 0;
        end
        if (!zcmn) mu[c] = gmn;
        else if (xing) mu[c] = gm;
        if (valid_i) begin
          pn[c] = (x < 0);
          y = (mu[c] || ap[c] >= 88) ? 0 : model_scale(x, ap[c]);
          if (c == 0) exp_l = y; else exp_r = y;
        end
      end
      exp_v = valid_i;
      gm = gmn; zcm = zcmn;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && started && !done) begin
      tests++;
      if (valid_o !== exp_v || $signed(left_o) != exp_l || $signed(right_o) != exp_r) begin
        fails++;
        $display("FAIL %s cycle model: got v=%0b l=%0d r=%0d exp v=%0b l=%0d r=%0d",
                 cur_req, valid_o, $signed(left_o), $signed(right_o), exp_v, exp_l, exp_r);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input bit v, input int l, input int r, input bit we, input int a, input int d);
    valid_i = v; left_i = 16'(l); right_i = 16'(r);
    wr_en_i = we; wr_addr_i = 2'(a); wr_data_i = 8'(d);
    @(negedge clk_i);
    wr_en_i = 1'b0; valid_i = 1'b0;
  endtask

  task automatic smp(input int l, input int r);
    cyc(1, l, r, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    cyc(0, 0, 0, 1, a, d);
  endtask

  task automatic chk(input string req, input int el, input int er);
    tests++;
    if ($signed(left_o) != el || $signed(right_o) != er) begin
      fails++;
      $display("FAIL %s: got l=%0d r=%0d exp l=%0d r=%0d", req, $signed(left_o), $signed(right_o), el, er);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    tests++;
    if (valid_o !== 1'b0 || left_o !== '0 || right_o !== '0) begin
      fails++;
      $display("FAIL R11 reset: got v=%0b l=%0d r=%0d exp 0 0 0", valid_o, left_o, right_o);
    end
    rst_ni = 1'b1;
    started = 1;
    @(negedge clk_i);

    cur_req = "R11"; smp(500, 500); chk("R11 mute after reset", 0, 0);

    cur_req = "R4"; wr(0, 16);
    smp(1000, 700);  chk("R4 armed not applied", 0, 0);
    smp(-1000, 700); chk("R4 applied at crossing", -1000, 0);

    cur_req = "R5"; wr(1, 22);
    smp(-800, 900);   chk("R5 right waits, left unchanged", -800, 0);
    smp(-800, -1001); chk("R5 right own crossing -6 dB", -800, -500);

    cur_req = "R6"; wr(0, 10);
    smp(-300, -1001); chk("R6 pending not yet", -300, -500);
    wr(0, 28);
    smp(-300, -1001); chk("R6 older value forced", -600, -500);
    smp(400, -1001);  chk("R6 newer applied at crossing", 100, -500);

    cur_req = "R3"; wr(0, 16);
    smp(400, -1001); chk("R3 no crossing same sign", 100, -500);
    smp(0, -1001);   chk("R3 zero sample is crossing", 0, -500);
    smp(400, -1001); chk("R3 gain took effect at zero", 400, -500);

    cur_req = "R2"; wr(1, 0);
    smp(400, 30000);  chk("R2 positive saturation", 400, 32767);
    smp(400, -30000); chk("R2 negative saturation", 400, -32768);
    smp(400, 7);      chk("R2 rounding +16 dB", 400, 44);
    cyc(0, 5, 5, 0, 0, 0);
    tests++;
    if (valid_o !== 1'b0 || $signed(left_o) != 400 || $signed(right_o) != 44) begin
      fails++;
      $display("FAIL R2 hold: got v=%0b l=%0d r=%0d exp 0 400 44", valid_o, $signed(left_o), $signed(right_o));
    end

    cur_req = "R1"; wr(0, 87);
    smp(-32767, 7); chk("R1 -71 dB gain", -9, 44);
    smp(32767, 7);  chk("R1 -71 dB gain positive", 9, 44);

    cur_req = "R7"; wr(0, 88);
    smp(32767, 7);  chk("R7 lowest step to mute immediate", 0, 44);
    wr(1, 88);
    smp(32767, 7);  chk("R7 other step to mute waits", 0, 44);
    smp(32767, -7); chk("R7 mute at crossing", 0, 0);

    cur_req = "R8"; wr(0, 16); wr(1, 16);
    smp(-500, 500); chk("R8 setup both 0 dB", -500, 500);
    wr(2, 1);
    smp(-600, 600); chk("R8 direct general mute", 0, 0);
    wr(2, 0);
    smp(-600, 600); chk("R8 direct unmute", -600, 600);

    cur_req = "R9"; wr(2, 2); wr(2, 3);
    smp(-700, 700); chk("R9 mute armed no crossing", -700, 700);
    smp(700, 700);  chk("R9 left crossing mutes left only", 0, 700);

    cur_req = "R10"; wr(2, 1);
    smp(700, 700);  chk("R10 clearing timing forces mute", 0, 0);
    wr(2, 3); wr(2, 2);
    cur_req = "R9";
    smp(700, 700);  chk("R9 unmute armed stays muted", 0, 0);
    cur_req = "R10"; wr(2, 0);
    smp(700, 700);  chk("R10 clearing timing forces unmute", 700, 700);

    cur_req = "R4";
    for (int i = 0; i < 40; i++) begin
      if (i % 7 == 0) wr(i % 2, (i * 13) % 90);
      smp((i % 3 == 0) ? -(i * 311) : i * 97, (i % 5 == 0) ? 0 : -(i * 211) + 3000);
    end
    finish_run();
  end
endmodule